// File: doc/BRIEF.md
# Request-Paced Multi-Channel DMA Engine

This block moves 32-bit words between one memory port and a set of peripheral channels. Each channel has three registers: a start address, a block descriptor that holds a word count per block and a number of blocks, and a control word. One global register holds a master enable bit for each channel. The highest-numbered channel does not talk to a device. It fills memory with zero words.

When software writes a descriptor, control or global register, or when a device raises its request line, the engine scans the channels. It visits them from index 0 upward and runs each eligible channel to a stopping point. It keeps making passes until a whole pass finds no channel to run. In request-paced mode a transfer is a series of fixed-size blocks. Every word of a block is moved back to back. The device request is looked at only in the gap after each block. If the request has dropped, the engine stores the next address and the number of blocks left into the channel's registers. The channel then waits for the request to rise again and resumes from that point.

Top module: `dma_engine`

## Requirements
- R1: After reset the global register reads 0x07654321 and every channel register reads 0. No memory or device strobe is active.
- R2: Register map. Channel c sits at byte offset 16*c: +0 is the 24-bit start address, +4 is the block descriptor (words per block in [15:0], block count in [31:16]) and +8 is control. The global register sits at 16*NUM_CH. Its bit 4*c+3 is the master enable of channel c. A channel with this bit clear never moves data, even when its control bits are set.
- R3: Every channel other than the zero-fill channel (index NUM_CH-1) also needs its devReq bit high before it can start. The zero-fill channel starts with its request low.
- R4: Control bits [10:9] select the mode: 0 is manual, 1 is request-paced, and 2 and 3 never run. Every channel needs control bit 24 (enable/busy) set. Manual mode also needs bit 28 (start) set, and then moves exactly one block.
- R5: Control bit 1 selects the address step: 0 steps +4 per word and 1 steps -4 per word. Addresses wrap within 24 bits.
- R6: Control bit 0 set means memory-to-device: memRe, with devWrValid[c] and devWrData equal to memRdata. Bit 0 clear means device-to-memory: devRdAck[c], with memWe and memWdata taken from that channel's devRdData. The zero-fill channel writes zero words to memory and never touches a device strobe.
- R7: In request-paced mode the engine moves (block count) blocks of (words per block) words. A block is never cut short, even if the request falls in the middle of it.
- R8: At a block boundary where blocks remain and the request is low, the engine stops. The start address then reads the next address, the block count reads the blocks left, and enable/busy stays set.
- R9: When the last block finishes, control bits 24 and 28 clear and doneCh[c] pulses for one cycle. The start address then reads the next address. In request-paced mode the block count reads 0.
- R10: A control write changes only the bits under mask 0x11000603. A write of all ones therefore reads back as 0x11000603.
- R11: When one event makes several channels eligible, the lower-numbered channel moves all of its words before a higher-numbered channel starts.
- R12: A rising devReq on a paused or waiting channel starts a scan, and the channel runs with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| devReq | input | NUM_CH | Per-channel device request |
| devRdData | input | 32*NUM_CH | Per-channel device data toward memory |
| devRdAck | output | NUM_CH | Device word consumed |
| devWrValid | output | NUM_CH | Device word presented on devWrData |
| devWrData | output | 32 | Data toward the device |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | MEM_AW | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, same cycle as memRe |
| doneCh | output | NUM_CH | One-cycle completion pulse per channel |

## Verification
The assertions take the memory to answer reads in the same cycle and to accept one word per cycle. They also take software to leave a channel's registers alone while that channel is moving data, and to program block sizes and counts that are not zero. The stimulus meets these conditions: every register write is followed by enough idle cycles for the engine to settle before the channel is touched again. A device model raises each request from a word budget, and some budgets end in the middle of a block so the request falls there. Memory read data is derived from the address, and device data is derived from a per-channel word counter. Both are therefore predictable words that the scoreboard queue can compare in order.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // Control word bit positions; the engine decodes these directly
  localparam int CC_TODEV  = 0;
  localparam int CC_STEPDN = 1;
  localparam int CC_SYNCLO = 9;
  localparam int CC_SYNCHI = 10;
  localparam int CC_ENABLE = 24;
  localparam int CC_START  = 28;
  localparam logic [31:0] CC_WMASK  = 32'h1100_0603;
  localparam logic [31:0] GLB_RESET = 32'h0765_4321;
  localparam int BLK_CNT_LSB = 16;

  typedef enum logic [1:0] {
    SYNC_MANUAL  = 2'd0,
    SYNC_REQUEST = 2'd1,
    SYNC_RSV2    = 2'd2,
    SYNC_RSV3    = 2'd3
  } syncMode_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SCAN, ST_XFER, ST_BLKEND
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // latch working copy of selected channel
    logic step;       // move one word
    logic reload;     // start next block of the active channel
    logic writeBack;  // store progress into channel registers
    logic finish;     // clear enable/start, pulse done
  } dpStrobe_t;
endpackage

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanTrig,
  input  logic [NUM_CH-1:0] elig,
  input  logic              lastWord,
  input  logic              blocksZero,
  input  logic              reqOk,
  output dpStrobe_t         strobe,
  output logic [CH_W-1:0]   selCh
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  ctlState_t state;
  logic [CH_W-1:0] idx;
  logic passHit;

  assign selCh = idx;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_SCAN:  strobe.load = elig[idx];
      ST_XFER:  strobe.step = 1'b1;
      ST_BLKEND: begin
        if (!blocksZero && reqOk) begin
          strobe.reload = 1'b1;
        end else begin
          strobe.writeBack = 1'b1;
          strobe.finish    = blocksZero;
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      passHit <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (scanTrig) begin
            state   <= ST_SCAN;
            idx     <= '0;
            passHit <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (elig[idx]) begin
            state   <= ST_XFER;
            passHit <= 1'b1;
          end else if (idx == LAST_CH) begin
            idx <= '0;
            if (passHit || scanTrig) passHit <= 1'b0;
            else                     state   <= ST_IDLE;
          end else begin
            idx <= idx + CH_W'(1);
            if (scanTrig) passHit <= 1'b1;
          end
        end
        ST_XFER: begin
          if (lastWord) state <= ST_BLKEND;
          if (scanTrig) passHit <= 1'b1;
        end
        ST_BLKEND: begin
          state <= strobe.reload ? ST_XFER : ST_SCAN;
          if (scanTrig) passHit <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CLR_CH = NUM_CH - 1,
  parameter int REG_AW = 8,
  parameter int MEM_AW = 24,
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int SEL_W = REG_AW - 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic [NUM_CH-1:0]      devReq,
  input  logic [NUM_CH*32-1:0]   devRdData,
  output logic [NUM_CH-1:0]      devRdAck,
  output logic [NUM_CH-1:0]      devWrValid,
  output logic [31:0]            devWrData,
  output logic                   memRe,
  output logic                   memWe,
  output logic [MEM_AW-1:0]      memAddr,
  output logic [31:0]            memWdata,
  input  logic [31:0]            memRdata,
  output logic [NUM_CH-1:0]      doneCh,
  input  dpStrobe_t              strobe,
  input  logic [CH_W-1:0]        selCh,
  output logic [NUM_CH-1:0]      elig,
  output logic                   lastWord,
  output logic                   blocksZero,
  output logic                   reqOk,
  output logic                   scanTrig
);
  // Channel register file
  logic [MEM_AW-1:0] baseR [NUM_CH];
  logic [SIZE_W-1:0] sizeR [NUM_CH];
  logic [CNT_W-1:0]  cntR  [NUM_CH];
  logic [31:0]       ctrlR [NUM_CH];
  logic [31:0]       glbR;

  // Working copy of the active channel
  logic [CH_W-1:0]   activeCh;
  logic [MEM_AW-1:0] curAddr;
  logic [SIZE_W-1:0] wordsLeft;
  logic [CNT_W-1:0]  blocksLeft;
  logic [NUM_CH-1:0] reqPrev;

  // Register address decode
  logic [SEL_W-1:0] chSel;
  logic [1:0]       field;
  logic             aligned, isCh, isGlb;
  logic [CH_W-1:0]  selIdx;

  assign chSel   = regAddr[REG_AW-1:4];
  assign field   = regAddr[3:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign isCh    = aligned && (chSel < SEL_W'(NUM_CH));
  assign isGlb   = aligned && (chSel == SEL_W'(NUM_CH)) && (field == 2'd0);
  assign selIdx  = chSel[CH_W-1:0];

  function automatic syncMode_t modeOf(input logic [31:0] c);
    return syncMode_t'(c[CC_SYNCHI:CC_SYNCLO]);
  endfunction

  // Scan triggers: descriptor/control/global writes, or rising request
  logic swTrig;
  assign swTrig   = regWe && ((isCh && (field == 2'd1 || field == 2'd2)) || isGlb);
  assign scanTrig = swTrig || |(devReq & ~reqPrev);

  // Eligibility per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
    syncMode_t m;
    logic reqNeed;
    assign m       = modeOf(ctrlR[c]);
    assign reqNeed = (c == CLR_CH) ? 1'b1 : devReq[c];
    assign elig[c] = glbR[4*c+3] && ctrlR[c][CC_ENABLE] && reqNeed &&
                     ((m == SYNC_MANUAL && ctrlR[c][CC_START]) || m == SYNC_REQUEST);
  end

  // Active-channel word movement
  logic isClr, toDev, stepDown, actReq;
  logic [MEM_AW-1:0] nextAddr;
  assign isClr    = (activeCh == CH_W'(CLR_CH));
  assign toDev    = ctrlR[activeCh][CC_TODEV] && !isClr;
  assign stepDown = ctrlR[activeCh][CC_STEPDN];
  assign actReq   = modeOf(ctrlR[activeCh]) == SYNC_REQUEST;
  assign nextAddr = stepDown ? curAddr - MEM_AW'(4) : curAddr + MEM_AW'(4);

  assign memRe     = strobe.step && toDev;
  assign memWe     = strobe.step && !toDev;
  assign memAddr   = curAddr;
  assign memWdata  = isClr ? 32'd0 : devRdData[32*activeCh +: 32];
  assign devWrData = memRdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dev
    logic hit;
    assign hit           = (activeCh == CH_W'(c));
    assign devWrValid[c] = strobe.step && hit && toDev;
    assign devRdAck[c]   = strobe.step && hit && !toDev && (c != CLR_CH);
    assign doneCh[c]     = strobe.finish && hit;
  end

  assign lastWord   = (wordsLeft == SIZE_W'(1));
  assign blocksZero = (blocksLeft == '0);
  assign reqOk      = devReq[activeCh] || isClr;

  // Working registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCh   <= '0;
      curAddr    <= '0;
      wordsLeft  <= '0;
      blocksLeft <= '0;
      reqPrev    <= '0;
    end else begin
      reqPrev <= devReq;
      if (strobe.load) begin
        activeCh   <= selCh;
        curAddr    <= baseR[selCh];
        wordsLeft  <= sizeR[selCh];
        blocksLeft <= (modeOf(ctrlR[selCh]) == SYNC_REQUEST) ? cntR[selCh] : CNT_W'(1);
      end
      if (strobe.step) begin
        curAddr   <= nextAddr;
        wordsLeft <= wordsLeft - SIZE_W'(1);
        if (lastWord) blocksLeft <= blocksLeft - CNT_W'(1);
      end
      if (strobe.reload) wordsLeft <= sizeR[activeCh];
    end
  end

  // Register file: software writes, then engine write-back wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      glbR <= GLB_RESET;
      for (int c = 0; c < NUM_CH; c++) begin
        baseR[c] <= '0;
        sizeR[c] <= '0;
        cntR[c]  <= '0;
        ctrlR[c] <= '0;
      end
    end else begin
      if (regWe && isGlb) glbR <= regWdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (regWe && isCh && selIdx == CH_W'(c)) begin
          unique case (field)
            2'd0: baseR[c] <= regWdata[MEM_AW-1:0];
            2'd1: begin
              sizeR[c] <= regWdata[SIZE_W-1:0];
              cntR[c]  <= regWdata[BLK_CNT_LSB +: CNT_W];
            end
            2'd2: ctrlR[c] <= (ctrlR[c] & ~CC_WMASK) | (regWdata & CC_WMASK);
            default: ;
          endcase
        end
        if (strobe.writeBack && activeCh == CH_W'(c)) begin
          baseR[c] <= curAddr;
          if (actReq) cntR[c] <= blocksLeft;
        end
        if (strobe.finish && activeCh == CH_W'(c)) begin
          ctrlR[c][CC_ENABLE] <= 1'b0;
          ctrlR[c][CC_START]  <= 1'b0;
        end
      end
    end
  end

  // Read-back
  always_comb begin
    regRdata = '0;
    if (isCh) begin
      unique case (field)
        2'd0: regRdata = 32'(baseR[selIdx]);
        2'd1: regRdata = {16'(cntR[selIdx]), 16'(sizeR[selIdx])};
        2'd2: regRdata = ctrlR[selIdx];
        default: regRdata = '0;
      endcase
    end else if (isGlb) begin
      regRdata = glbR;
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CLR_CH = NUM_CH - 1,
  parameter int REG_AW = 8,
  parameter int MEM_AW = 24,
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [NUM_CH-1:0]    devReq,
  input  logic [NUM_CH*32-1:0] devRdData,
  output logic [NUM_CH-1:0]    devRdAck,
  output logic [NUM_CH-1:0]    devWrValid,
  output logic [31:0]          devWrData,
  output logic                 memRe,
  output logic                 memWe,
  output logic [MEM_AW-1:0]    memAddr,
  output logic [31:0]          memWdata,
  input  logic [31:0]          memRdata,
  output logic [NUM_CH-1:0]    doneCh
);
  dpStrobe_t         strobe;
  logic [CH_W-1:0]   selCh;
  logic [NUM_CH-1:0] elig;
  logic lastWord, blocksZero, reqOk, scanTrig;

  dma_control #(.NUM_CH(NUM_CH)) u_ctl (
    .clk(clk), .rstN(rstN), .scanTrig(scanTrig), .elig(elig),
    .lastWord(lastWord), .blocksZero(blocksZero), .reqOk(reqOk),
    .strobe(strobe), .selCh(selCh)
  );

  dma_datapath #(
    .NUM_CH(NUM_CH), .CLR_CH(CLR_CH), .REG_AW(REG_AW),
    .MEM_AW(MEM_AW), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .devReq(devReq),
    .devRdData(devRdData), .devRdAck(devRdAck), .devWrValid(devWrValid),
    .devWrData(devWrData), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .doneCh(doneCh),
    .strobe(strobe), .selCh(selCh), .elig(elig), .lastWord(lastWord),
    .blocksZero(blocksZero), .reqOk(reqOk), .scanTrig(scanTrig)
  );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int CLR_CH = NUM_CH - 1,
  parameter int MEM_AW = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRe,
  input logic              memWe,
  input logic [MEM_AW-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic [NUM_CH-1:0] devWrValid,
  input logic [NUM_CH-1:0] devRdAck,
  input logic [NUM_CH-1:0] doneCh
);
  logic acc;
  assign acc = memRe || memWe;

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R6
  AST_DEVWR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rstN)
    (|devWrValid) |-> memRe); // R6
  AST_DEVRD_NEEDS_WR: assert property (@(posedge clk) disable iff (!rstN)
    (|devRdAck) |-> memWe); // R6
  AST_DEV_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({devWrValid, devRdAck})); // R6
  AST_CLR_NO_DEV: assert property (@(posedge clk) disable iff (!rstN)
    !devWrValid[CLR_CH] && !devRdAck[CLR_CH]); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !(|devRdAck)) |-> memWdata == 32'd0); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (acc && $past(acc)) |-> (memAddr == MEM_AW'($past(memAddr) + MEM_AW'(4)) ||
                             memAddr == MEM_AW'($past(memAddr) - MEM_AW'(4)))); // R5
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneCh)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|doneCh) |=> doneCh == '0); // R9
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (|doneCh) |-> !acc); // R7
endmodule

bind dma_engine dma_engine_chk #(.NUM_CH(NUM_CH), .CLR_CH(CLR_CH), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .devWrValid(devWrValid), .devRdAck(devRdAck), .doneCh(doneCh)
);

// File: tb/test_dma_engine.sv
module test_dma_engine;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int MAW = 24;
  localparam logic [7:0] GLB = 8'h40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, regWe;
  logic [AW-1:0] regAddr;
  logic [31:0] regWdata, regRdata, devWrData, memWdata, memRdata;
  logic [NCH-1:0] devReq, devRdAck, devWrValid, doneCh;
  logic [NCH*32-1:0] devRdData;
  logic memRe, memWe;
  logic [MAW-1:0] memAddr;

  dma_engine i_dma_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .devReq(devReq), .devRdData(devRdData), .devRdAck(devRdAck),
    .devWrValid(devWrValid), .devWrData(devWrData), .memRe(memRe), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .doneCh(doneCh)
  );

  // Memory and device models
  int granted[NCH];
  int used[NCH];
  int doneSeen[NCH];
  assign memRdata = {8'h5A, memAddr};
  for (genvar c = 0; c < NCH; c++) begin : g_devm
    assign devReq[c] = granted[c] > used[c];
    assign devRdData[32*c +: 32] = {4'hD, 4'(c), 24'(used[c])};
    always @(posedge clk) if (devWrValid[c] || devRdAck[c]) used[c] <= used[c] + 1;
  end

  typedef struct {
    int kind;            // 0 to device, 1 from device, 2 zero fill
    int ch;
    logic [MAW-1:0] addr;
    logic [31:0] data;
  } item_t;
  item_t expQ[$];
  int expUsed[NCH];
  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (memRe || memWe) begin
        item_t a, e;
        a.kind = memRe ? 0 : ((|devRdAck) ? 1 : 2);
        a.ch = NCH - 1;
        for (int c = 0; c < NCH; c++) if (devWrValid[c] || devRdAck[c]) a.ch = c;
        a.addr = memAddr;
        a.data = memRe ? devWrData : memWdata;
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R2/R3/R4 unexpected word: actual kind=%0d ch=%0d addr=%h data=%h expected none",
                   a.kind, a.ch, a.addr, a.data);
        end else begin
          e = expQ.pop_front();
          // R5 address order, R6 direction/data, R7 block words, R11 channel order
          if (a.kind != e.kind || a.ch != e.ch || a.addr != e.addr || a.data != e.data) begin
            bad++;
            $display("FAIL R5/R6/R7/R11 word: actual kind=%0d ch=%0d addr=%h data=%h expected kind=%0d ch=%0d addr=%h data=%h",
                     a.kind, a.ch, a.addr, a.data, e.kind, e.ch, e.addr, e.data);
          end
        end
      end
      for (int c = 0; c < NCH; c++) if (doneCh[c]) doneSeen[c]++;
    end
  end

  task automatic expWords(input int kind, input int ch, input logic [MAW-1:0] base,
                          input int n, input bit down);
    logic [MAW-1:0] a = base;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.kind = kind; it.ch = ch; it.addr = a;
      if (kind == 0) begin
        it.data = {8'h5A, a}; expUsed[ch]++;
      end else if (kind == 1) begin
        it.data = {4'hD, 4'(ch), 24'(expUsed[ch])}; expUsed[ch]++;
      end else begin
        it.data = 32'd0;
      end
      expQ.push_back(it);
      a = down ? a - MAW'(4) : a + MAW'(4);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regAddr = a; #1;
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qEmpty(input string tag);
    chk(expQ.size() == 0, tag, 32'(expQ.size()), 32'd0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    granted[0] = 1000; granted[1] = 1000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk(GLB, 32'h0765_4321, "R1 global reset");
    rdChk(8'h08, 32'h0, "R1 ch0 control reset");
    rdChk(8'h24, 32'h0, "R1 ch2 block reset");
    chk(!memRe && !memWe && devWrValid == 0 && devRdAck == 0 && doneCh == 0, "R1 idle strobes",
        {memRe, memWe, devWrValid, devRdAck, doneCh}, 32'h0);

    // R2 master enable gate; then manual to-device, step up (R5, R6, R9)
    wr(8'h00, 32'h100); wr(8'h04, 32'h3); wr(8'h08, 32'h1100_0001);
    settle(20);
    qEmpty("R2 no words with master off");
    rdChk(8'h08, 32'h1100_0001, "R2 control kept while master off");
    expWords(0, 0, 24'h100, 3, 1'b0);
    wr(GLB, 32'h0765_4329);
    settle(30);
    qEmpty("R2 manual words after master on");
    rdChk(8'h00, 32'h10C, "R9 base after manual");
    rdChk(8'h08, 32'h0000_0001, "R9 enable/start cleared");
    chk(doneSeen[0] == 1, "R9 done ch0", 32'(doneSeen[0]), 32'd1);

    // R4 manual without start bit; R5 wrap stepping down; R6 device-to-memory
    wr(GLB, 32'h0765_43A9);
    wr(8'h10, 32'h4); wr(8'h14, 32'h3); wr(8'h18, 32'h0100_0002);
    settle(20);
    qEmpty("R4 manual needs start");
    rdChk(8'h18, 32'h0100_0002, "R4 control unchanged");
    expWords(1, 1, 24'h000004, 3, 1'b1);
    wr(8'h18, 32'h1100_0002);
    settle(30);
    qEmpty("R5 wrap words");
    rdChk(8'h10, 32'hFF_FFF8, "R5 address wraps in 24 bits");

    // R3 request needed; R7 block not cut; R8 pause write-back; R12 resume on rising request
    wr(8'h20, 32'h300); wr(8'h24, 32'h0003_0002); wr(8'h28, 32'h0100_0201);
    wr(GLB, 32'h0765_4BA9);
    settle(20);
    qEmpty("R3 no start without request");
    expWords(0, 2, 24'h300, 4, 1'b0);
    @(negedge clk); granted[2] = 3;   // request falls inside the second block
    settle(40);
    qEmpty("R7 second block completes after request fall");
    rdChk(8'h20, 32'h310, "R8 base written back");
    rdChk(8'h24, 32'h0001_0002, "R8 blocks left written back");
    rdChk(8'h28, 32'h0100_0201, "R8 enable stays set");
    chk(doneSeen[2] == 0, "R8 no done on pause", 32'(doneSeen[2]), 32'd0);
    expWords(0, 2, 24'h310, 2, 1'b0);
    @(negedge clk); granted[2] = 6;
    settle(30);
    qEmpty("R12 resume on rising request");
    rdChk(8'h20, 32'h318, "R9 base after request mode");
    rdChk(8'h24, 32'h0000_0002, "R9 count zero");
    rdChk(8'h28, 32'h0000_0201, "R9 enable cleared");
    chk(doneSeen[2] == 1, "R9 done ch2", 32'(doneSeen[2]), 32'd1);

    // R3 zero-fill channel runs without request; R6 zero words
    wr(8'h30, 32'h200); wr(8'h34, 32'h0002_0002); wr(8'h38, 32'h0100_0200);
    expWords(2, 3, 24'h200, 4, 1'b0);
    wr(GLB, 32'h0765_CBA9);
    settle(30);
    qEmpty("R3 zero-fill words");
    rdChk(8'h30, 32'h210, "R3 zero-fill base");
    chk(doneSeen[3] == 1, "R9 done ch3", 32'(doneSeen[3]), 32'd1);

    // R4 reserved modes never run
    wr(8'h08, 32'h1100_0401);
    settle(20);
    qEmpty("R4 reserved mode idle");
    rdChk(8'h08, 32'h1100_0401, "R4 reserved control kept");
    wr(8'h08, 32'h0);

    // R10 write mask
    wr(8'h18, 32'hFFFF_FFFF);
    settle(20);
    rdChk(8'h18, 32'h1100_0603, "R10 masked control");
    qEmpty("R10 mode 3 idle");
    wr(8'h18, 32'h0);

    // R11 index order for one enabling event
    wr(GLB, 32'h0765_4321);
    wr(8'h00, 32'h500); wr(8'h04, 32'h2); wr(8'h08, 32'h1100_0001);
    wr(8'h10, 32'h600); wr(8'h14, 32'h2); wr(8'h18, 32'h1100_0000);
    expWords(0, 0, 24'h500, 2, 1'b0);
    expWords(1, 1, 24'h600, 2, 1'b0);
    wr(GLB, 32'h0765_43A9);
    settle(40);
    qEmpty("R11 both channels served in order");
    chk(doneSeen[0] == 2 && doneSeen[1] == 2, "R9 done counts ch0/ch1",
        32'(doneSeen[0] * 16 + doneSeen[1]), 32'h22);

    finishRun();
  end
endmodule